// File: doc/BRIEF.md
# Serial Configuration Loader with Start Delay

This block takes a 104-bit configuration word from a host over a slow three-wire serial link: a shift clock, a data line and a load strobe. The word is assembled in a shift register. When the strobe arrives after exactly 104 bits, the word is moved into a shadow register. The new word does not act on the rest of the chip yet. It becomes visible on the active configuration output only once a start delay has run out.

The delay is armed by an edge of a vertical-sync input. The lowest byte of the shadow word gives a count N, and the delay lasts N × `UNIT_CYC` reference-clock cycles. The default unit is 1024 cycles, which gives about 227.6 µs per step with a 4.5 MHz reference; N = 255 gives about 58 ms. Bit 96 of the active word (bit 0 of the last byte) selects which vsync edge arms the delay. A wait flag is high for the whole delay, and the host shifts in its next word during that time. An N of zero stops the delay from starting, so the active word cannot change. All serial and vsync inputs go through two-flop synchronizers into the reference-clock domain, and the block needs that clock running at all times.

Top module: `cfg_delay_loader`

## Requirements
- R1: Synchronous reset drives `cfg_active` to all zeros and `wait_o` low.
- R2: Serial bits are taken least significant first on rising shift-clock edges. The k-th bit shifted (k = 0..103) lands in bit k of the word, so byte b occupies bits 8b..8b+7.
- R3: A load strobe (rising edge) moves the assembled word into the shadow only if exactly 104 bits were shifted since the previous strobe. Otherwise the strobe is ignored and the shadow keeps its contents. Every strobe restarts the bit count.
- R4: Once armed, `wait_o` stays high for exactly N × `UNIT_CYC` reference-clock cycles, where N is bits 7:0 of the shadow word.
- R5: `cfg_active` changes only in the cycle where `wait_o` falls, and it then takes the shadow value.
- R6: If bits 7:0 of the shadow are zero, a vsync edge arms nothing: `wait_o` stays low and `cfg_active` is unchanged.
- R7: Active bit 96 selects the arming edge. 0 means a rising vsync edge arms the delay, 1 means a falling edge does. The other edge is ignored.
- R8: An arming edge during a running delay restarts the full count from the current shadow N. No copy takes place at the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, least significant bit first |
| ser_load | input | 1 | Load strobe, acts on its rising edge |
| vsync | input | 1 | Vertical-sync input that arms the delay |
| cfg_active | output | 104 | Active configuration word |
| wait_o | output | 1 | High while the start delay runs |

## Verification
The bench measures the wait-flag width for N = 1, N = 255 and random N. An off-by-one in the unit or step counter shows up as a length error of one cycle or of one whole unit. Strobes after 103 and after 105 bits must leave the shadow untouched; a design that accepts them would commit a shifted copy of the word. A zero count must arm nothing. A vsync edge mid-delay must stretch the flag by exactly the edge spacing, and a design that ignores the edge or commits at the restart fails this. In falling-edge mode a rising edge is applied first and must have no effect; a design with a fixed polarity would start the delay early.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= '0;
      else     st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter #(
  parameter int BITS = 104,
  localparam int CW  = $clog2(BITS + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk_s,
  input  logic            sdat_s,
  input  logic            load_s,
  output logic [BITS-1:0] shadow_q,
  output logic [CW-1:0]   bit_cnt
);
  logic            sclk_d, load_d;
  logic [BITS-1:0] sr_q;
  logic            shift_ev, load_ev;

  assign shift_ev = sclk_s & ~sclk_d;
  assign load_ev  = load_s & ~load_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      load_d   <= 1'b0;
      sr_q     <= '0;
      bit_cnt  <= '0;
      shadow_q <= '0;
    end else begin
      sclk_d <= sclk_s;
      load_d <= load_s;
      if (load_ev) begin
        if (bit_cnt == CW'(BITS)) shadow_q <= sr_q;
        bit_cnt <= '0;
      end else if (shift_ev) begin
        sr_q <= {sdat_s, sr_q[BITS-1:1]};
        if (bit_cnt != CW'(BITS + 1)) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgld_timer.sv
module cfgld_timer #(
  parameter int NW       = 8,
  parameter int UNIT_CYC = 1024,
  localparam int UW      = $clog2(UNIT_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] n_val,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] step_q,
  output logic [UW-1:0] unit_q
);
  logic unit_end;

  assign unit_end = (unit_q == '0);
  assign done     = busy & ~start & unit_end & (step_q == NW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      step_q <= '0;
      unit_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      step_q <= n_val;
      unit_q <= UW'(UNIT_CYC - 1);
    end else if (busy) begin
      if (unit_end) begin
        if (step_q == NW'(1)) begin
          busy   <= 1'b0;
          step_q <= '0;
        end else begin
          step_q <= step_q - 1'b1;
          unit_q <= UW'(UNIT_CYC - 1);
        end
      end else begin
        unit_q <= unit_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_delay_loader.sv
module cfg_delay_loader #(
  parameter int BYTES       = 13,
  parameter int BYTE_W      = 8,
  parameter int UNIT_CYC    = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ser_clk,
  input  logic                     ser_dat,
  input  logic                     ser_load,
  input  logic                     vsync,
  output logic [BYTES*BYTE_W-1:0]  cfg_active,
  output logic                     wait_o
);
  import cfgld_pkg::*;

  localparam int BITS     = BYTES * BYTE_W;
  localparam int EDGE_BIT = BITS - BYTE_W;
  localparam int CW       = $clog2(BITS + 2);
  localparam int UW       = $clog2(UNIT_CYC + 1);

  logic            sclk_s, sdat_s, load_s, vs_s, vs_d;
  logic [BITS-1:0] shadow_q;
  logic [CW-1:0]   bit_cnt;
  logic [BYTE_W-1:0] step_q;
  logic [UW-1:0]   unit_q;
  logic            vs_edge, start, busy, done;
  edge_sel_e       edge_mode;

  cfgld_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_clk, ser_dat, ser_load, vsync}),
    .q   ({sclk_s, sdat_s, load_s, vs_s})
  );

  cfgld_shifter #(.BITS(BITS)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (sclk_s),
    .sdat_s   (sdat_s),
    .load_s   (load_s),
    .shadow_q (shadow_q),
    .bit_cnt  (bit_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) vs_d <= 1'b0;
    else     vs_d <= vs_s;
  end

  assign edge_mode = edge_sel_e'(cfg_active[EDGE_BIT]);
  assign vs_edge   = (edge_mode == EDGE_FALL) ? (vs_d & ~vs_s) : (vs_s & ~vs_d);
  assign start     = vs_edge & (shadow_q[BYTE_W-1:0] != '0);

  cfgld_timer #(.NW(BYTE_W), .UNIT_CYC(UNIT_CYC)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .n_val  (shadow_q[BYTE_W-1:0]),
    .busy   (busy),
    .done   (done),
    .step_q (step_q),
    .unit_q (unit_q)
  );

  always_ff @(posedge clk) begin
    if (rst)       cfg_active <= '0;
    else if (done) cfg_active <= shadow_q;
  end

  assign wait_o = busy;
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
  parameter int BITS     = 104,
  parameter int NW       = 8,
  parameter int UNIT_CYC = 1024,
  parameter int CW       = 7,
  parameter int UW       = 11
) (
  input logic            clk,
  input logic            rst,
  input logic [BITS-1:0] cfg_active,
  input logic            wait_o,
  input logic [BITS-1:0] shadow_q,
  input logic [NW-1:0]   step_q,
  input logic [UW-1:0]   unit_q,
  input logic [CW-1:0]   bit_cnt
);
  // R5: active word moves only when the wait flag drops
  p_active_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_active) |-> $fell(wait_o));

  // R5: the committed value is the shadow seen one cycle earlier
  p_commit_copy_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(wait_o) |-> (cfg_active == $past(shadow_q)));

  // R6: a delay only starts from a nonzero count
  p_nonzero_start_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(wait_o) |-> ($past(shadow_q[NW-1:0]) != '0));

  // R4: counters stay in range while the delay runs
  p_counter_live_r4: assert property (@(posedge clk) disable iff (rst)
    wait_o |-> ((step_q != '0) && (unit_q < UW'(UNIT_CYC))));

  // R3: bit counter saturates one past the word length
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CW'(BITS + 1));
endmodule

bind cfg_delay_loader cfgld_checker #(
  .BITS(BITS), .NW(BYTE_W), .UNIT_CYC(UNIT_CYC), .CW(CW), .UW(UW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_active (cfg_active),
  .wait_o     (wait_o),
  .shadow_q   (shadow_q),
  .step_q     (step_q),
  .unit_q     (unit_q),
  .bit_cnt    (bit_cnt)
);

// File: tb/sim_cfg_delay_loader.sv
module sim_cfg_delay_loader;
  localparam int CLK_PERIOD = 10;
  localparam int U          = 8;
  localparam int W          = 104;

  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_load = 1'b0, vsync = 1'b0;
  logic [W-1:0] cfg_active;
  logic wait_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [W-1:0] exp_active = '0;
  logic [W-1:0] exp_shadow = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_delay_loader #(.UNIT_CYC(U)) u0 (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_load(ser_load), .vsync(vsync), .cfg_active(cfg_active), .wait_o(wait_o)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bits(logic [W-1:0] w, int nb);
    for (int i = 0; i < nb; i++) begin
      ser_dat = w[i % W];
      tick(3);
      ser_clk = 1'b1;
      tick(3);
      ser_clk = 1'b0;
    end
  endtask

  task automatic strobe();
    ser_load = 1'b1;
    tick(3);
    ser_load = 1'b0;
    tick(4);
  endtask

  task automatic load_word(logic [W-1:0] w);
    shift_bits(w, W);
    strobe();
    exp_shadow = w;
  endtask

  // counts negedges with wait high; checks R5 hold while waiting
  task automatic count_wait(output int n);
    int t = 0;
    bit held = 1'b1;
    while (!wait_o && t < 200) begin tick(1); t++; end
    n = 0;
    while (wait_o && n < 5000) begin
      if (cfg_active !== exp_active) held = 1'b0;
      n++;
      tick(1);
    end
    if (n > 0) check(held, "R5 hold during wait", cfg_active, exp_active);
    tick(2);
  endtask

  task automatic fire_rise(output int n);
    vsync = 1'b0;
    tick(5);
    vsync = 1'b1;
    count_wait(n);
  endtask

  function automatic logic [W-1:0] rand_word(int nmax, bit fall);
    logic [W-1:0] w;
    w = {$urandom(), $urandom(), $urandom(), $urandom()};
    w[7:0] = 8'(1 + ($urandom() % nmax));
    w[96]  = fall;
    return w;
  endfunction

  task automatic commit_case(logic [W-1:0] w, string tag);
    int n;
    load_word(w);
    fire_rise(n);
    check(n == int'(w[7:0]) * U, {tag, " R4 wait length"}, W'(n), W'(int'(w[7:0]) * U));
    exp_active = w;
    check(cfg_active === exp_active, {tag, " R2 committed word"}, cfg_active, exp_active);
  endtask

  initial begin
    int n;
    logic [W-1:0] w;
    void'($urandom(32'd1234));
    tick(10);
    check(cfg_active === '0, "R1 reset active", cfg_active, '0);
    check(wait_o === 1'b0, "R1 reset wait", W'(wait_o), '0);
    rst = 1'b0;
    tick(5);

    // R2 directed: distinct bytes expose ordering errors
    for (int b = 0; b < 13; b++) w[b*8 +: 8] = 8'({b[3:0], ~b[3:0]});
    w[7:0] = 8'd5;
    w[96]  = 1'b0;
    commit_case(w, "dir");

    for (int k = 0; k < 8; k++) commit_case(rand_word(12, 1'b0), "rnd");

    w = rand_word(12, 1'b0); w[7:0] = 8'd1;
    commit_case(w, "N1");
    w = rand_word(12, 1'b0); w[7:0] = 8'd255;
    commit_case(w, "N255");

    // R3: short and long shifts are ignored
    w = rand_word(12, 1'b0); w[7:0] = 8'd7;
    shift_bits(w, W - 1); strobe();
    fire_rise(n);
    check(n == 255 * U, "R3 103-bit strobe ignored length", W'(n), W'(255 * U));
    check(cfg_active === exp_active, "R3 103-bit strobe ignored", cfg_active, exp_active);
    shift_bits(w, W + 1); strobe();
    fire_rise(n);
    check(n == 255 * U, "R3 105-bit strobe ignored length", W'(n), W'(255 * U));
    check(cfg_active === exp_active, "R3 105-bit strobe ignored", cfg_active, exp_active);

    // R6: zero count arms nothing
    w = rand_word(12, 1'b0); w[7:0] = 8'd0;
    load_word(w);
    fire_rise(n);
    check(n == 0, "R6 zero count no wait", W'(n), '0);
    check(cfg_active === exp_active, "R6 zero count no update", cfg_active, exp_active);

    // R8: restart 30 cycles after first edge
    w = rand_word(12, 1'b0); w[7:0] = 8'd10;
    load_word(w);
    vsync = 1'b0; tick(5); vsync = 1'b1;
    n = 0;
    for (int i = 1; i < 3000; i++) begin
      tick(1);
      if (i == 20) vsync = 1'b0;
      if (i == 30) vsync = 1'b1;
      if (wait_o) n++;
      else if (n > 0) break;
    end
    tick(2);
    check(n == 10 * U + 30, "R8 restart length", W'(n), W'(10 * U + 30));
    exp_active = w;
    check(cfg_active === exp_active, "R8 restart commit", cfg_active, exp_active);

    // R7: falling-edge mode
    w = rand_word(12, 1'b1); w[7:0] = 8'd3;
    commit_case(w, "F");
    w = rand_word(12, 1'b1); w[7:0] = 8'd2;
    load_word(w);
    vsync = 1'b0;
    count_wait(n);
    check(n == 2 * U, "R7 falling edge arms", W'(n), W'(2 * U));
    exp_active = w;
    check(cfg_active === exp_active, "R7 falling commit", cfg_active, exp_active);
    w = rand_word(12, 1'b0); w[7:0] = 8'd3;
    load_word(w);
    vsync = 1'b1;
    count_wait(n);
    check(n == 0, "R7 rising ignored in falling mode", W'(n), '0);
    check(cfg_active === exp_active, "R7 rising no update", cfg_active, exp_active);
    vsync = 1'b0;
    count_wait(n);
    check(n == 3 * U, "R7 falling edge arms again", W'(n), W'(3 * U));
    exp_active = w;
    check(cfg_active === exp_active, "R7 second falling commit", cfg_active, exp_active);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule